// File: doc/BRIEF.md
# Buffered SPI Payload Port with 16-Byte FIFO

This block is the payload side of a radio transceiver's host interface. A second SPI slave port, separate from the configuration port, moves data bytes between the host and a 16-entry byte FIFO while buffered operation is enabled. Frames carry no address. Each low period of the data select moves exactly one byte, so the host must raise the select and lower it again between bytes. In transmit mode the host fills the FIFO and the modulator side drains it. In receive mode the demodulator side fills the FIFO and the host drains it over the same port.

All SPI pins are brought into the system clock domain through synchronizers and oversampled there. A frame state machine has four states. FR_IDLE waits for the port to be selected. FR_SHIFT counts rising SCK edges. FR_FULL holds once eight bits have arrived and ignores further clocks. FR_COMMIT is a single cycle in which the FIFO operation for the finished byte happens. The transitions are:

- FR_IDLE→FR_SHIFT when the port becomes selected. The outgoing byte is snapshotted at this point.
- FR_SHIFT→FR_FULL on the eighth rising SCK edge.
- FR_SHIFT→FR_IDLE when the select is released early. The partial frame is discarded.
- FR_FULL→FR_COMMIT when the select is released.
- FR_COMMIT→FR_IDLE unconditionally.

Two interrupt lines report FIFO status. A mapping register chooses what each line shows. The configuration port writes this register through a decoded strobe.

Top module: `buf_spi_data_port`

## Requirements
- R1: The port takes part in a frame only while `buffered_en`=1, `nss_data`=0 and `nss_cfg`=1. At all other times SCK activity changes nothing, and `miso_oe` stays 0 (MISO released).
- R2: Bits move most significant first. MOSI is sampled on rising SCK and MISO advances on falling SCK. A byte is committed when the select rises after at least 8 rising edges. Rising edges beyond the eighth are ignored.
- R3: If the select rises after fewer than 8 rising SCK edges, the frame is discarded and the FIFO is left unchanged.
- R4: The FIFO holds 16 bytes and returns them in the order they were written.
- R5: In transmit mode (`rx_mode`=0), each completed host byte is appended to the FIFO. A host byte that arrives while the FIFO is full is dropped and sets the sticky `ovf_flag`.
- R6: In receive mode (`rx_mode`=1), a host frame shifts out the FIFO head that was present when the select fell, then removes it. A frame that starts with the FIFO empty shifts out 0x00 and, on completion, sets the sticky `udf_flag`.
- R7: In transmit mode, `tx_valid`/`tx_byte` show the FIFO head and `tx_pop` removes it. In receive mode, `rx_push` appends `rx_data`. A push while the FIFO is full is dropped and sets `ovf_flag`.
- R8: A push and a pop in the same cycle both take effect. A push to a full FIFO in the cycle it is popped is accepted and does not set `ovf_flag`.
- R9: `cfg_map_we` loads `cfg_map_data` into the mapping register. Bits [1:0] select the line-0 source and bits [3:2] the line-1 source. After reset the register is 0, and both lines and both flags are low.
- R10: Line-0 source codes: 0 = held low; 1 = FIFO not empty; 2 = a one-cycle pulse in the cycle after each byte is accepted into the FIFO; 3 = FIFO empty.
- R11: Line-1 source codes: 0 = held low; 1 = FIFO full; 2 = a one-cycle pulse in the cycle after the FIFO becomes full; 3 = the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buffered_en | input | 1 | Buffered operation enable (configuration bit) |
| rx_mode | input | 1 | 1 = receive mode, 0 = transmit mode |
| cfg_map_we | input | 1 | Decoded write strobe for the interrupt mapping register |
| cfg_map_data | input | 4 | New mapping value: [1:0] line 0, [3:2] line 1 |
| nss_cfg | input | 1 | Configuration-port select, active low |
| nss_data | input | 1 | Data-port select, active low |
| sck | input | 1 | SPI clock, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | MISO drive enable; 0 = high impedance |
| rx_push | input | 1 | Receive datapath writes `rx_data` into the FIFO |
| rx_data | input | 8 | Byte from the receive datapath |
| tx_pop | input | 1 | Transmit datapath takes the FIFO head |
| tx_byte | output | 8 | FIFO head presented to the transmit datapath |
| tx_valid | output | 1 | FIFO holds at least one byte |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
The host-side commit of a received byte can fall in the same clock cycle as a write from the receive datapath. This collision matters most when the FIFO is full. To provoke it, the bench fills the FIFO with 16 bytes, starts a host read, and times `rx_push` so that it lands on the FR_COMMIT cycle: three clock edges after the select rises, counted through the two-stage synchronizer. The bench judges the outcome only at the ports. `ovf_flag` must stay low, and a full drain must return the 15 remaining original bytes followed by the byte pushed during the collision.

// File: rtl/buf_spi_pkg.sv
package buf_spi_pkg;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_SHIFT  = 2'd1,
        FR_FULL   = 2'd2,
        FR_COMMIT = 2'd3
    } frame_state_t;

    typedef enum logic [1:0] {
        L0_OFF       = 2'd0,
        L0_NOT_EMPTY = 2'd1,
        L0_WR_PULSE  = 2'd2,
        L0_EMPTY     = 2'd3
    } line0_src_t;

    typedef enum logic [1:0] {
        L1_OFF       = 2'd0,
        L1_FULL      = 2'd1,
        L1_FULL_EDGE = 2'd2,
        L1_OVERFLOW  = 2'd3
    } line1_src_t;

endpackage

// File: rtl/buf_spi_sync.sv
module buf_spi_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= RST_VAL;
                    else        stg_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= RST_VAL;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/buf_spi_fifo.sv
module buf_spi_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     count_q;

    assign empty = (count_q == '0);
    assign full  = (count_q == CW'(DEPTH));
    assign count = count_q;
    assign head  = mem_q[rd_ptr_q];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wrap_inc(wr_ptr_q);
            if (pop)  rd_ptr_q <= wrap_inc(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/buf_spi_framer.sv
module buf_spi_framer
    import buf_spi_pkg::*;
#(
    parameter int  BYTE_W = 8,
    localparam int BCW    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_act,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              rd_mode,
    input  logic [BYTE_W-1:0] head,
    input  logic              head_empty,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              commit_o,
    output logic              commit_rd_o,
    output logic              commit_empty_o,
    output logic [BYTE_W-1:0] byte_o
);

    frame_state_t      state_q, state_d;
    logic [BCW-1:0]    bit_cnt_q;
    logic [BYTE_W-1:0] in_sh_q, out_sh_q;
    logic              sck_prev_q, mode_q, empty_q;
    logic              sck_rise, sck_fall;

    assign sck_rise = sck_s  & ~sck_prev_q;
    assign sck_fall = ~sck_s &  sck_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:   if (sel_act) state_d = FR_SHIFT;
            FR_SHIFT: begin
                if (!sel_act)
                    state_d = FR_IDLE;
                else if (sck_rise && bit_cnt_q == BCW'(BYTE_W - 1))
                    state_d = FR_FULL;
            end
            FR_FULL:   if (!sel_act) state_d = FR_COMMIT;
            FR_COMMIT: state_d = FR_IDLE;
        endcase
    end

    // shifters and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            bit_cnt_q  <= '0;
            in_sh_q    <= '0;
            out_sh_q   <= '0;
            mode_q     <= 1'b0;
            empty_q    <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            unique case (state_q)
                FR_IDLE: begin
                    if (sel_act) begin
                        bit_cnt_q <= '0;
                        in_sh_q   <= '0;
                        mode_q    <= rd_mode;
                        empty_q   <= rd_mode & head_empty;
                        out_sh_q  <= (rd_mode && !head_empty) ? head : '0;
                    end
                end
                FR_SHIFT: begin
                    if (sck_rise) begin
                        in_sh_q   <= {in_sh_q[BYTE_W-2:0], mosi_s};
                        bit_cnt_q <= bit_cnt_q + BCW'(1);
                    end
                    if (sck_fall)
                        out_sh_q <= {out_sh_q[BYTE_W-2:0], 1'b0};
                end
                FR_FULL, FR_COMMIT: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        miso_o         = out_sh_q[BYTE_W-1];
        byte_o         = in_sh_q;
        commit_rd_o    = mode_q;
        commit_empty_o = empty_q;
        miso_oe_o      = 1'b0;
        commit_o       = 1'b0;
        unique case (state_q)
            FR_IDLE:   ;
            FR_SHIFT:  miso_oe_o = 1'b1;
            FR_FULL:   miso_oe_o = 1'b1;
            FR_COMMIT: commit_o  = 1'b1;
        endcase
    end

endmodule

// File: rtl/buf_spi_irq.sv
module buf_spi_irq
    import buf_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       map_we,
    input  logic [3:0] map_data,
    input  logic       empty,
    input  logic       full,
    input  logic       wr_evt,
    input  logic       ovf,
    output logic [3:0] map_o,
    output logic       irq0,
    output logic       irq1
);

    logic [3:0] map_q;
    logic       wr_evt_q, full_q;
    line0_src_t src0;
    line1_src_t src1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= '0;
            wr_evt_q <= 1'b0;
            full_q   <= 1'b0;
        end else begin
            if (map_we) map_q <= map_data;
            wr_evt_q <= wr_evt;
            full_q   <= full;
        end
    end

    assign src0  = line0_src_t'(map_q[1:0]);
    assign src1  = line1_src_t'(map_q[3:2]);
    assign map_o = map_q;

    always_comb begin
        irq0 = 1'b0;
        unique case (src0)
            L0_OFF:       irq0 = 1'b0;
            L0_NOT_EMPTY: irq0 = ~empty;
            L0_WR_PULSE:  irq0 = wr_evt_q;
            L0_EMPTY:     irq0 = empty;
        endcase
    end

    always_comb begin
        irq1 = 1'b0;
        unique case (src1)
            L1_OFF:       irq1 = 1'b0;
            L1_FULL:      irq1 = full;
            L1_FULL_EDGE: irq1 = full & ~full_q;
            L1_OVERFLOW:  irq1 = ovf;
        endcase
    end

endmodule

// File: rtl/buf_spi_data_port.sv
module buf_spi_data_port
    import buf_spi_pkg::*;
#(
    parameter int  DATA_W      = 8,
    parameter int  FIFO_DEPTH  = 16,
    parameter int  SYNC_STAGES = 2,
    localparam int CW          = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buffered_en,
    input  logic              rx_mode,
    input  logic              cfg_map_we,
    input  logic [3:0]        cfg_map_data,
    input  logic              nss_cfg,
    input  logic              nss_data,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_valid,
    output logic              irq0,
    output logic              irq1,
    output logic              ovf_flag,
    output logic              udf_flag
);

    logic [3:0]        pins_s;
    logic              sck_s, mosi_s, nss_data_s, nss_cfg_s, sel_act;
    logic              commit, commit_rd, commit_empty;
    logic              host_wr, host_rd;
    logic [DATA_W-1:0] host_byte, fifo_head, fifo_din;
    logic [CW-1:0]     fifo_count;
    logic              fifo_empty, fifo_full;
    logic              push_req, pop_req, push_ok, pop_ok;
    logic              ovf_q, udf_q;
    logic [3:0]        irq_map;

    buf_spi_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({nss_cfg, nss_data, mosi, sck}),
        .dout  (pins_s)
    );

    assign {nss_cfg_s, nss_data_s, mosi_s, sck_s} = pins_s;
    assign sel_act = buffered_en & ~nss_data_s & nss_cfg_s;

    buf_spi_framer #(.BYTE_W(DATA_W)) u_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_act        (sel_act),
        .sck_s          (sck_s),
        .mosi_s         (mosi_s),
        .rd_mode        (rx_mode),
        .head           (fifo_head),
        .head_empty     (fifo_empty),
        .miso_o         (miso),
        .miso_oe_o      (miso_oe),
        .commit_o       (commit),
        .commit_rd_o    (commit_rd),
        .commit_empty_o (commit_empty),
        .byte_o         (host_byte)
    );

    assign host_wr  = commit & ~commit_rd;
    assign host_rd  = commit &  commit_rd;

    assign push_req = host_wr | (rx_mode & rx_push);
    assign pop_req  = (host_rd & ~commit_empty) | (~rx_mode & tx_pop);
    assign fifo_din = host_wr ? host_byte : rx_data;
    assign pop_ok   = pop_req & ~fifo_empty;
    assign push_ok  = push_req & (~fifo_full | pop_ok);

    buf_spi_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .din   (fifo_din),
        .pop   (pop_ok),
        .head  (fifo_head),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (push_req && !push_ok)     ovf_q <= 1'b1;
            if (host_rd && commit_empty)  udf_q <= 1'b1;
        end
    end

    assign ovf_flag = ovf_q;
    assign udf_flag = udf_q;
    assign tx_byte  = fifo_head;
    assign tx_valid = ~fifo_empty;

    buf_spi_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (cfg_map_we),
        .map_data (cfg_map_data),
        .empty    (fifo_empty),
        .full     (fifo_full),
        .wr_evt   (push_ok),
        .ovf      (ovf_q),
        .map_o    (irq_map),
        .irq0     (irq0),
        .irq1     (irq1)
    );

endmodule

// File: rtl/buf_spi_data_port_chk.sv
module buf_spi_data_port_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          push_req,
    input logic          pop_ok,
    input logic          host_wr,
    input logic          host_rd,
    input logic          commit_empty,
    input logic          ovf_flag,
    input logic          udf_flag,
    input logic          miso_oe,
    input logic          buffered_en,
    input logic [3:0]    irq_map,
    input logic          irq0,
    input logic          irq1
);

    // R4: occupancy never exceeds the depth
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(FIFO_DEPTH));

    // R5 / R7: a rejected push leaves the overflow flag set
    a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full && !pop_ok) |=> ovf_flag);

    // R8: push and pop together when full keep the FIFO full and raise no overflow
    a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_ok && fifo_full && !ovf_flag) |=> (fifo_full && !ovf_flag));

    // R6: empty read raises underflow, which then stays set
    a_r6_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && commit_empty) |=> udf_flag);

    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag |=> udf_flag);

    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R2: a frame commits as either a write or a read, for one cycle only
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr || host_rd) |=> !(host_wr || host_rd));

    a_r2_commit_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_wr, host_rd}));

    // R1: port cannot start driving while buffered mode is off
    a_r1_no_drive_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!buffered_en && !miso_oe) |=> !miso_oe);

    // R9: an unmapped line stays low
    a_r9_line0_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_map[1:0] == 2'd0) |-> !irq0);

    a_r9_line1_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_map[3:2] == 2'd0) |-> !irq1);

endmodule

bind buf_spi_data_port buf_spi_data_port_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CW         (CW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_count   (fifo_count),
    .fifo_full    (fifo_full),
    .push_req     (push_req),
    .pop_ok       (pop_ok),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .commit_empty (commit_empty),
    .ovf_flag     (ovf_flag),
    .udf_flag     (udf_flag),
    .miso_oe      (miso_oe),
    .buffered_en  (buffered_en),
    .irq_map      (irq_map),
    .irq0         (irq0),
    .irq1         (irq1)
);

// File: tb/sim_buf_spi_data_port.sv
module sim_buf_spi_data_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       buffered_en = 1'b0, rx_mode = 1'b0;
    logic       cfg_map_we = 1'b0;
    logic [3:0] cfg_map_data = '0;
    logic       nss_cfg = 1'b1, nss_data = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_valid, irq0, irq1, ovf_flag, udf_flag;

    int n_checks = 0, n_fail = 0;
    logic [7:0] got_byte;
    logic       seen_oe;

    always #5 clk = ~clk;

    buf_spi_data_port u0 (
        .clk(clk), .rst_n(rst_n), .buffered_en(buffered_en), .rx_mode(rx_mode),
        .cfg_map_we(cfg_map_we), .cfg_map_data(cfg_map_data),
        .nss_cfg(nss_cfg), .nss_data(nss_data), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .rx_push(rx_push), .rx_data(rx_data),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .irq0(irq0), .irq1(irq1), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nss_data = 1'b1; nss_cfg = 1'b1; sck = 1'b0; mosi = 1'b0;
        rx_push = 1'b0; tx_pop = 1'b0; cfg_map_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_map(input logic [3:0] m);
        @(negedge clk);
        cfg_map_data = m; cfg_map_we = 1'b1;
        @(negedge clk);
        cfg_map_we = 1'b0;
    endtask

    // one select-low period; MSB first; optional rx_push on the commit cycle
    task automatic spi_frame(input logic [15:0] out_bits, input int nbits,
                             input bit coll_push, input logic [7:0] coll_data);
        got_byte = '0;
        seen_oe  = 1'b0;
        @(negedge clk);
        nss_data = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = out_bits[nbits-1-i];
            repeat (4) @(negedge clk);
            if (i < 8) got_byte = {got_byte[6:0], miso};
            seen_oe = seen_oe | miso_oe;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        nss_data = 1'b1;
        repeat (3) @(negedge clk);
        if (coll_push) begin
            rx_data = coll_data; rx_push = 1'b1;
        end
        @(negedge clk);
        rx_push = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic push_rx(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 irq0 after reset", irq0, 0);
        chk("R9 irq1 after reset", irq1, 0);
        chk("R9 ovf after reset", ovf_flag, 0);
        chk("R9 udf after reset", udf_flag, 0);
        chk("R1 miso_oe idle", miso_oe, 0);
        chk("R4 empty after reset", tx_valid, 0);
    endtask

    task automatic t_tx_basic();
        do_reset();
        buffered_en = 1'b1; rx_mode = 1'b0;
        spi_frame(16'hA5, 8, 0, 0);
        chk("R1 miso_oe during frame", seen_oe, 1);
        chk("R1 miso_oe released", miso_oe, 0);
        chk("R2 tx write valid", tx_valid, 1);
        chk("R2 tx write byte MSB first", tx_byte, 8'hA5);
        spi_frame(16'h3C, 5, 0, 0);
        chk("R3 short frame discarded (head)", tx_byte, 8'hA5);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        chk("R3 short frame added nothing", tx_valid, 0);
        spi_frame(16'b1100_0011_01, 10, 0, 0);
        chk("R2 extra clocks ignored", tx_byte, 8'hC3);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        chk("R7 tx_pop drains", tx_valid, 0);
    endtask

    task automatic t_gating();
        do_reset();
        buffered_en = 1'b1; rx_mode = 1'b0;
        nss_cfg = 1'b0;
        spi_frame(16'h5A, 8, 0, 0);
        nss_cfg = 1'b1;
        chk("R1 cfg select blocks data port", tx_valid, 0);
        chk("R1 no drive when cfg selected", seen_oe, 0);
        buffered_en = 1'b0;
        spi_frame(16'h5A, 8, 0, 0);
        chk("R1 buffered mode off blocks port", tx_valid, 0);
        chk("R1 no drive when not buffered", seen_oe, 0);
    endtask

    task automatic t_tx_fill();
        do_reset();
        buffered_en = 1'b1; rx_mode = 1'b0;
        set_map(4'b0100);
        for (int i = 0; i < 16; i++) spi_frame(16'(8'h40 + i), 8, 0, 0);
        chk("R11 line1 full level", irq1, 1);
        chk("R5 no overflow at 16", ovf_flag, 0);
        spi_frame(16'hEE, 8, 0, 0);
        chk("R5 write to full sets ovf", ovf_flag, 1);
        set_map(4'b1100);
        chk("R11 line1 shows overflow", irq1, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R4 FIFO order", tx_byte, 8'h40 + i);
            @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        end
        chk("R5 dropped byte absent", tx_valid, 0);
    endtask

    task automatic t_rx();
        do_reset();
        buffered_en = 1'b1; rx_mode = 1'b1;
        set_map(4'b0010);
        @(negedge clk);
        rx_data = 8'h96; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R10 write pulse high", irq0, 1);
        @(negedge clk);
        chk("R10 write pulse one cycle", irq0, 0);
        set_map(4'b0001);
        chk("R10 not-empty level", irq0, 1);
        spi_frame(16'h00, 8, 0, 0);
        chk("R6 host read MSB first", got_byte, 8'h96);
        chk("R10 not-empty drops after read", irq0, 0);
        chk("R6 no underflow on valid read", udf_flag, 0);
        spi_frame(16'hFF, 8, 0, 0);
        chk("R6 empty read returns zero", got_byte, 8'h00);
        chk("R6 empty read sets udf", udf_flag, 1);
        set_map(4'b0011);
        chk("R10 empty level", irq0, 1);
    endtask

    task automatic t_rx_full();
        do_reset();
        buffered_en = 1'b1; rx_mode = 1'b1;
        set_map(4'b1000);
        for (int i = 0; i < 15; i++) push_rx(8'h10 + i);
        chk("R11 no edge before full", irq1, 0);
        @(negedge clk); rx_data = 8'h1F; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
        chk("R11 full edge pulse", irq1, 1);
        @(negedge clk);
        chk("R11 full edge one cycle", irq1, 0);
        spi_frame(16'h00, 8, 1, 8'h77);
        chk("R6 read during collision", got_byte, 8'h10);
        chk("R8 collision push accepted", ovf_flag, 0);
        for (int i = 1; i < 16; i++) begin
            spi_frame(16'h00, 8, 0, 0);
            chk("R8 drain order", got_byte, 8'h10 + i);
        end
        spi_frame(16'h00, 8, 0, 0);
        chk("R8 collided byte last", got_byte, 8'h77);
        for (int i = 0; i < 16; i++) push_rx(8'h80 + i);
        push_rx(8'hEE);
        chk("R7 rx push to full sets ovf", ovf_flag, 1);
    endtask

    initial begin
        t_reset();
        t_tx_basic();
        t_gating();
        t_tx_fill();
        t_rx();
        t_rx_full();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule